// File: doc/BRIEF.md
# SD Host Vendor Register Front-End

This block sits in front of an SD/eMMC host controller and decodes a 4 KiB register window on a simple 32-bit register bus. The bottom 256 bytes hold 64 word-wide vendor host registers. A separate 256-byte region is forwarded to an external standard-compatible slot register block. Everything else in the window is empty.

Three host registers have write behaviour of their own. The identification word at offset 0x000 carries a self-clearing software reset. This reset restores every host register and also pulses a reset to the slot block. The PHY access port at offset 0x010 acknowledges a request at once. The eMMC control word at offset 0x018 reports any tuning request as already finished. Every access must be an aligned four-byte access. Any other access is refused with an error pulse.

Read data is registered and appears on the cycle after the read strobe. Slot accesses are presented on the slot port in the same cycle as the bus access. The slot's read data is sampled in that same cycle.

Top module: `sdhost_vreg_frontend`

## Requirements
- R1: After power-on reset, host word 0x000 reads 0x00010000 and every other host word reads 0.
- R2: A valid write to 0x000 with bit 0 set returns all 64 host words to their R1 values. Bit 0 of 0x000 always reads 0, and a write to 0x000 with bit 0 clear changes nothing.
- R3: A write to 0x010 stores the data with bit 26 replaced by (bit 24 OR bit 25) of the written value.
- R4: A write to 0x018 stores the data with bit 15 forced to 0.
- R5: A write to any other host offset from 0x004 to 0x0FC stores all 32 bits unchanged.
- R6: Offsets 0x100–0x1FF and 0x300–0xFFF read as 0, and writes there modify no host word.
- R7: An access in 0x200–0x2FF asserts slot_req_o in the same cycle. It sets slot_we_o/slot_re_o to match the strobes, puts the offset minus 0x200 on slot_addr_o and passes wdata_i through. A read returns slot_rdata_i on rdata_o one cycle later.
- R8: An access with size_i not equal to 4 (size_i is a byte count), or with addr_i[1:0] not 0, raises err_o for the following cycle. It is not forwarded, changes no state, and a read returns 0.
- R9: slot_reset_o is high for exactly one cycle after the first clock edge following reset release. It is also high for the cycle after a software reset write.
- R10: rdata_o changes only on the cycle after a read strobe. When a read and a write hit the same address in one cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| size_i | input | 3 | Access size in bytes |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Refused-access pulse |
| slot_req_o | output | 1 | Slot access request |
| slot_we_o | output | 1 | Slot write strobe |
| slot_re_o | output | 1 | Slot read strobe |
| slot_addr_o | output | 8 | Byte offset within the slot region |
| slot_wdata_o | output | 32 | Write data to slot |
| slot_rdata_i | input | 32 | Read data from slot, same cycle |
| slot_reset_o | output | 1 | Slot reset pulse |

## Verification
The bench raises the read and write strobes together on one address in a single cycle. It expects the registered read data to carry the value from before the write, and expects a read issued afterwards to return the new value. It also issues a software reset write that the slot reset pulse must follow in the next cycle. In that cycle the host words are already back at their reset values, which the read-back after the pulse confirms.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
  typedef enum logic [1:0] {
    RGN_HOST = 2'd0,
    RGN_SLOT = 2'd1,
    RGN_NONE = 2'd2
  } region_e;
endpackage

// File: rtl/sdv_decode.sv
module sdv_decode
  import sdv_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SIZE_W     = 3,
  parameter int WORD_BYTES = 4,
  parameter int HOST_BYTES = 256,
  parameter int SLOT_BASE  = 512,
  parameter int SLOT_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              aligned_o,
  output region_e           rgn_o
);
  localparam int LSB_W = $clog2(WORD_BYTES);
  localparam int SLOT_END = SLOT_BASE + SLOT_BYTES;

  int unsigned a;
  assign a = int'(addr_i);

  assign aligned_o = (size_i == SIZE_W'(WORD_BYTES)) && (addr_i[LSB_W-1:0] == '0);

  always_comb begin
    if (a < HOST_BYTES)                      rgn_o = RGN_HOST;
    else if (a >= SLOT_BASE && a < SLOT_END) rgn_o = RGN_SLOT;
    else                                     rgn_o = RGN_NONE;
  end
endmodule

// File: rtl/sdv_hostregs.sv
module sdv_hostregs #(
  parameter int              DATA_W      = 32,
  parameter int              WORDS       = 64,
  parameter int              IDX_W       = $clog2(WORDS),
  parameter int              ID_IDX      = 0,
  parameter int              PHY_IDX     = 4,
  parameter int              EMMC_IDX    = 6,
  parameter int              SWR_BIT     = 0,
  parameter int              PHY_WR_BIT  = 24,
  parameter int              PHY_RD_BIT  = 25,
  parameter int              PHY_ACK_BIT = 26,
  parameter int              TUNE_BIT    = 15,
  parameter logic [DATA_W-1:0] ID_RESET  = 32'h0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              swr_o
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] shaped;

  assign swr_o = wr_i && (idx_i == IDX_W'(ID_IDX)) && wdata_i[SWR_BIT];

  always_comb begin
    shaped = wdata_i;
    if (idx_i == IDX_W'(PHY_IDX))
      shaped[PHY_ACK_BIT] = wdata_i[PHY_WR_BIT] | wdata_i[PHY_RD_BIT];
    if (idx_i == IDX_W'(EMMC_IDX))
      shaped[TUNE_BIT] = 1'b0;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == ID_IDX) begin : g_id
      // read-only apart from the self-clearing reset bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    mem[g] <= ID_RESET;
        else if (swr_o) mem[g] <= ID_RESET;
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              mem[g] <= '0;
        else if (swr_o)                           mem[g] <= '0;
        else if (wr_i && idx_i == IDX_W'(g))      mem[g] <= shaped;
      end
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/sdv_slot_rst.sv
module sdv_slot_rst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swr_i,
  output logic pulse_o
);
  logic por_q;
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q   <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      por_q   <= 1'b0;
      pulse_q <= por_q | swr_i;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sdhost_vreg_frontend.sv
module sdhost_vreg_frontend
  import sdv_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int SIZE_W     = 3,
  parameter int HOST_WORDS = 64,
  parameter int SLOT_BASE  = 512,
  parameter int SLOT_BYTES = 256,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int LSB_W      = $clog2(WORD_BYTES),
  localparam int IDX_W      = $clog2(HOST_WORDS),
  localparam int SLOT_AW    = $clog2(SLOT_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [SIZE_W-1:0]  size_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic               slot_req_o,
  output logic               slot_we_o,
  output logic               slot_re_o,
  output logic [SLOT_AW-1:0] slot_addr_o,
  output logic [DATA_W-1:0]  slot_wdata_o,
  input  logic [DATA_W-1:0]  slot_rdata_i,
  output logic               slot_reset_o
);
  logic              aligned;
  region_e           rgn;
  logic              acc;
  logic              host_wr;
  logic              swr;
  logic [DATA_W-1:0] host_rd;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  sdv_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_BYTES(WORD_BYTES),
    .HOST_BYTES(HOST_WORDS * WORD_BYTES),
    .SLOT_BASE(SLOT_BASE), .SLOT_BYTES(SLOT_BYTES)
  ) u_dec (
    .addr_i(addr_i), .size_i(size_i), .aligned_o(aligned), .rgn_o(rgn)
  );

  assign acc     = we_i | re_i;
  assign host_wr = we_i & aligned & (rgn == RGN_HOST);

  sdv_hostregs #(
    .DATA_W(DATA_W), .WORDS(HOST_WORDS), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(host_wr),
    .idx_i(addr_i[IDX_W+LSB_W-1:LSB_W]), .wdata_i(wdata_i),
    .rdata_o(host_rd), .swr_o(swr)
  );

  sdv_slot_rst u_srst (
    .clk_i(clk_i), .rst_ni(rst_ni), .swr_i(swr), .pulse_o(slot_reset_o)
  );

  // slot base is a multiple of the slot size, so the low bits are the offset
  assign slot_req_o   = acc & aligned & (rgn == RGN_SLOT);
  assign slot_we_o    = slot_req_o & we_i;
  assign slot_re_o    = slot_req_o & re_i;
  assign slot_addr_o  = addr_i[SLOT_AW-1:0];
  assign slot_wdata_o = wdata_i;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (rgn)
        RGN_HOST: rd_mux = host_rd;
        RGN_SLOT: rd_mux = slot_rdata_i;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (re_i) rdata_q <= rd_mux;
      err_q <= acc & ~aligned;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sdv_checker.sv
module sdv_checker #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int SIZE_W     = 3,
  parameter int SLOT_BASE  = 512,
  parameter int SLOT_BYTES = 256,
  parameter int HOST_BYTES = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              we_i,
  input logic              re_i,
  input logic              swr_bit_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              slot_req_o,
  input logic              slot_we_o,
  input logic              slot_re_o,
  input logic              slot_reset_o
);
  logic bad, good, in_slot, in_gap;
  assign bad     = (we_i | re_i) && (size_i != SIZE_W'(DATA_W / 8) || addr_i[1:0] != 2'b00);
  assign good    = (size_i == SIZE_W'(DATA_W / 8)) && (addr_i[1:0] == 2'b00);
  assign in_slot = int'(addr_i) >= SLOT_BASE && int'(addr_i) < SLOT_BASE + SLOT_BYTES;
  assign in_gap  = int'(addr_i) >= HOST_BYTES && !in_slot;

  a_r8_err_after_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> err_o);
  a_r8_quiet_when_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad |=> !err_o);
  a_r8_bad_not_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |-> !slot_req_o);
  a_r7_slot_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> in_slot);
  a_r7_slot_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> (slot_we_o == we_i && slot_re_o == re_i));
  a_r9_swr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && good && addr_i == '0 && swr_bit_i) |=> slot_reset_o);
  a_r2_swr_bit_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && good && addr_i == '0) |=> !rdata_o[0]);
  a_r6_gap_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && good && in_gap) |=> rdata_o == '0);
  a_r10_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind sdhost_vreg_frontend sdv_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
  .SLOT_BASE(SLOT_BASE), .SLOT_BYTES(SLOT_BYTES),
  .HOST_BYTES(HOST_WORDS * (DATA_W / 8))
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .size_i(size_i),
  .we_i(we_i), .re_i(re_i), .swr_bit_i(wdata_i[0]), .rdata_o(rdata_o),
  .err_o(err_o), .slot_req_o(slot_req_o), .slot_we_o(slot_we_o),
  .slot_re_o(slot_re_o), .slot_reset_o(slot_reset_o)
);

// File: tb/sim_sdhost_vreg_frontend.sv
`timescale 1ns/1ps
module sim_sdhost_vreg_frontend;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  size = 3'd4;
  logic [31:0] rdata, slot_wdata, slot_rdata;
  logic        err, slot_req, slot_we, slot_re, slot_reset;
  logic [7:0]  slot_addr;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;
  assign slot_rdata = {24'hC0FFEE, slot_addr};

  sdhost_vreg_frontend u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .size_i(size), .rdata_o(rdata), .err_o(err),
    .slot_req_o(slot_req), .slot_we_o(slot_we), .slot_re_o(slot_re),
    .slot_addr_o(slot_addr), .slot_wdata_o(slot_wdata),
    .slot_rdata_i(slot_rdata), .slot_reset_o(slot_reset)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd3, 12'h010, 32'h0100_0000, 32'h0500_0000}, // R3 write request
    '{4'd3, 12'h010, 32'h0200_0000, 32'h0600_0000}, // R3 read request
    '{4'd3, 12'h010, 32'h0400_0000, 32'h0000_0000}, // R3 ack alone cleared
    '{4'd3, 12'h010, 32'h0300_0123, 32'h0700_0123}, // R3 both requests
    '{4'd4, 12'h018, 32'h0000_FFFF, 32'h0000_7FFF}, // R4
    '{4'd4, 12'h018, 32'hFFFF_8000, 32'hFFFF_0000}, // R4
    '{4'd5, 12'h004, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R5
    '{4'd5, 12'h0FC, 32'h1234_5678, 32'h1234_5678}, // R5 last word
    '{4'd5, 12'h014, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R5 neighbour of PHY port
    '{4'd2, 12'h000, 32'hFFFF_FFFE, 32'h0001_0000}, // R2 bit 0 clear: no effect
    '{4'd6, 12'h104, 32'hA5A5_A5A5, 32'h0000_0000}, // R6 low gap
    '{4'd6, 12'h3F0, 32'hA5A5_A5A5, 32'h0000_0000}  // R6 high gap
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] s);
    @(negedge clk);
    addr = a; wdata = d; size = s; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0; size = 3'd4;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; re = 1'b1; we = 1'b0;
    @(negedge clk);
    re = 1'b0; size = 3'd4;
    d = rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(9, {31'd0, slot_reset}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(9, {31'd0, slot_reset}, 32'd1);     // R9 power-on pulse
    @(negedge clk);
    chk(9, {31'd0, slot_reset}, 32'd0);
    chk(10, rdata, 32'd0);

    // R1 reset state
    rd(12'h000, 3'd4, v); chk(1, v, 32'h0001_0000);
    rd(12'h010, 3'd4, v); chk(1, v, 32'h0);
    rd(12'h0FC, 3'd4, v); chk(1, v, 32'h0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      wr(VECS[i].a, VECS[i].d, 3'd4);
      rd(VECS[i].a, 3'd4, v);
      chk(int'(VECS[i].req), v, VECS[i].e);
    end
    // R6 gap write at 0x104 must not alias host word 0x004
    rd(12'h004, 3'd4, v); chk(6, v, 32'hDEAD_BEEF);

    // R10 simultaneous read and write of one address
    wr(12'h008, 32'h1111_1111, 3'd4);
    @(negedge clk);
    addr = 12'h008; wdata = 32'h2222_2222; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    chk(10, rdata, 32'h1111_1111);
    repeat (2) @(negedge clk);
    chk(10, rdata, 32'h1111_1111);          // R10 holds without read
    rd(12'h008, 3'd4, v); chk(10, v, 32'h2222_2222);

    // R7 slot forwarding
    @(negedge clk);
    addr = 12'h2A4; wdata = 32'h5A5A_0001; we = 1'b1;
    #1;
    chk(7, {29'd0, slot_req, slot_we, slot_re}, 32'b110);
    chk(7, {24'd0, slot_addr}, 32'hA4);
    chk(7, slot_wdata, 32'h5A5A_0001);
    @(negedge clk);
    we = 1'b0;
    rd(12'h2FC, 3'd4, v); chk(7, v, 32'hC0FFEEFC);
    rd(12'h300, 3'd4, v); chk(6, v, 32'h0);

    // R8 refused accesses
    wr(12'h006, 32'hFFFF_FFFF, 3'd4);
    chk(8, {31'd0, err}, 32'd1);
    @(negedge clk);
    chk(8, {31'd0, err}, 32'd0);
    wr(12'h004, 32'h0BAD_0BAD, 3'd2);
    chk(8, {31'd0, err}, 32'd1);
    rd(12'h004, 3'd4, v); chk(8, v, 32'hDEAD_BEEF);
    rd(12'h004, 3'd1, v); chk(8, v, 32'h0);
    chk(8, {31'd0, err}, 32'd1);
    wr(12'h000, 32'h1, 3'd2);
    chk(8, {31'd0, slot_reset}, 32'd0);
    @(negedge clk);
    addr = 12'h204; size = 3'd2; we = 1'b1;
    #1;
    chk(8, {31'd0, slot_req}, 32'd0);
    @(negedge clk);
    we = 1'b0; size = 3'd4;

    // R2 / R9 software reset
    wr(12'h000, 32'h0000_0001, 3'd4);
    chk(9, {31'd0, slot_reset}, 32'd1);
    @(negedge clk);
    chk(9, {31'd0, slot_reset}, 32'd0);
    rd(12'h004, 3'd4, v); chk(2, v, 32'h0);
    rd(12'h018, 3'd4, v); chk(2, v, 32'h0);
    rd(12'h000, 3'd4, v); chk(2, v, 32'h0001_0000);

    summary();
    $finish;
  end
endmodule